// File: doc/BRIEF.md
# Bitwise Logic Execution Unit with Condition Flags

This block is the logical slice of a processor execute stage. It combines a first operand with a second operand that an upstream shifter has already prepared, and applies one of eight bitwise functions chosen by a 3-bit opcode. The shifter's carry-out arrives on its own input. The unit does not compute a carry of its own.

The logical result and its write-enable are combinational outputs, so the writeback path sees them in the same cycle the operation is presented. The four condition flags live in a register inside the block. The six writing functions change the flags only when the caller asks for it. The two probe functions exist only to set flags: they always update them and never request a register write. The overflow flag is never written by any operation; only reset clears it.

Top module: `bitop_unit`

## Requirements
- R1: With the encoding 000 AND (a&b), 001 OR (a|b), 010 XOR (a^b), 011 NOT (~b), 100 CLEAR (a&~b), 101 ORNOT (a|~b), 110 PROBE_AND (a&b), 111 PROBE_XOR (a^b), `res_data` equals the listed function of `src_a` and `src_b` in the same cycle.
- R2: For opcode 011 the result does not depend on `src_a`.
- R3: `res_we` is high exactly when `in_valid` is high and the opcode is one of 000 to 101; it is low for 110 and 111 and whenever `in_valid` is low.
- R4: On a valid cycle with opcode 000 to 101 and `set_flags` low, all four flags keep their previous values after the clock edge.
- R5: On a valid cycle with opcode 110 or 111, the flags update whatever the level of `set_flags`.
- R6: When flags update, `flag_n` takes the top bit (bit W-1) of the result after the clock edge.
- R7: When flags update, `flag_z` is 1 after the clock edge exactly when every bit of the result is 0.
- R8: When flags update, `flag_c` takes the value on `shift_carry` after the clock edge, for both 0 and 1.
- R9: `flag_v` is never changed by any operation.
- R10: When `in_valid` is low, the flags hold whatever `set_flags` and the opcode are.
- R11: A synchronous active-high `rst` clears all four flags to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Function select, encoding in R1 |
| src_a | input | W | First operand |
| src_b | input | W | Shifted second operand |
| shift_carry | input | 1 | Carry-out from the second-operand shifter |
| set_flags | input | 1 | Request flag update for writing operations |
| res_data | output | W | Logical result |
| res_we | output | 1 | Result write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
On every cycle the assertions check the write-enable gating, that the flags hold when no update is called for, and that N, Z and C after an update match the previous cycle's result and shifter carry. They also check that V never moves. Whether each opcode computes the right function, whether NOT really ignores the first operand, and whether reset clears flags that were set can only be shown by the bench's scenarios. These compare the outputs with a reference model over random operands and directed corner values.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_AND      = 3'b000,
        OP_OR       = 3'b001,
        OP_XOR      = 3'b010,
        OP_NOT      = 3'b011,
        OP_CLEAR    = 3'b100,
        OP_ORNOT    = 3'b101,
        OP_PROBE_A  = 3'b110,
        OP_PROBE_X  = 3'b111
    } bitop_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    // Probe operations share the top two opcode bits
    function automatic logic is_probe(input logic [2:0] op);
        return op[2] & op[1];
    endfunction

endpackage

// File: rtl/bitop_alu.sv
module bitop_alu #(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    import bitop_pkg::*;

    logic [W-1:0] b_inv;
    logic [W-1:0] b_eff;

    // Inverting variants select ~b once, then share the and/or gates
    always_comb begin
        b_inv = ~b;
        unique case (bitop_op_e'(op))
            OP_NOT, OP_CLEAR, OP_ORNOT: b_eff = b_inv;
            default:                    b_eff = b;
        endcase
    end

    always_comb begin
        unique case (bitop_op_e'(op))
            OP_AND, OP_CLEAR, OP_PROBE_A: y = a & b_eff;
            OP_OR,  OP_ORNOT:             y = a | b_eff;
            OP_XOR, OP_PROBE_X:           y = a ^ b_eff;
            OP_NOT:                       y = b_eff;
            default:                      y = '0;
        endcase
    end

endmodule

// File: rtl/bitop_flagcalc.sv
module bitop_flagcalc #(
    parameter int W = 32
) (
    input  logic [W-1:0]       y,
    input  logic               carry_in,
    input  bitop_pkg::flags_t  cur,
    input  logic               update,
    output bitop_pkg::flags_t  nxt
);
    import bitop_pkg::*;

    localparam int TOP = W - 1;

    logic zero;

    assign zero = (y == '0);

    always_comb begin
        nxt = cur;
        if (update) begin
            nxt.n = y[TOP];
            nxt.z = zero;
            nxt.c = carry_in;
            // v deliberately left at cur.v
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [2:0]   opcode,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         shift_carry,
    input  logic         set_flags,
    output logic [W-1:0] res_data,
    output logic         res_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    import bitop_pkg::*;

    flags_t       flags_q;
    flags_t       flags_calc;
    flags_t       flags_d;
    logic [W-1:0] result;
    logic         probe;
    logic         upd;

    bitop_alu #(.W(W)) u_alu (
        .op (opcode),
        .a  (src_a),
        .b  (src_b),
        .y  (result)
    );

    bitop_flagcalc #(.W(W)) u_flag (
        .y        (result),
        .carry_in (shift_carry),
        .cur      (flags_q),
        .update   (upd),
        .nxt      (flags_calc)
    );

    always_comb begin
        probe   = is_probe(opcode);
        upd     = in_valid & (probe | set_flags);
        flags_d = rst ? FLAGS_RESET : flags_calc;
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign res_data = result;
    assign res_we   = in_valid & ~probe;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_c   = flags_q.c;
    assign flag_v   = flags_q.v;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   opcode,
    input logic         shift_carry,
    input logic         set_flags,
    input logic [W-1:0] res_data,
    input logic         res_we,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);
    logic probe_op;
    logic do_upd;
    assign probe_op = opcode[2] & opcode[1];
    assign do_upd   = in_valid & (probe_op | set_flags);

    assert_we_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !res_we);

    assert_we_probe_R3: assert property (@(posedge clk) disable iff (rst)
        probe_op |-> !res_we);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !do_upd |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_c)));

    assert_probe_c_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && probe_op && !set_flags) |=> (flag_c == $past(shift_carry)));

    assert_n_R6: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (flag_n == $past(res_data[W-1])));

    assert_z_R7: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (flag_z == ($past(res_data) == '0)));

    assert_c_R8: assert property (@(posedge clk) disable iff (rst)
        do_upd |=> (flag_c == $past(shift_carry)));

    assert_v_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(flag_v));

endmodule

bind bitop_unit bitop_unit_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .opcode      (opcode),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .res_data    (res_data),
    .res_we      (res_we),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   opcode;
    logic [W-1:0] src_a, src_b;
    logic         shift_carry, set_flags;
    logic [W-1:0] res_data;
    logic         res_we, flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [3:0] mflags;  // model {n,z,c,v}

    always #2 clk = ~clk;

    bitop_unit #(.W(W)) u_dut (.*);

    function automatic logic [W-1:0] ref_res(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b010: return a ^ b;
            3'b011: return ~b;
            3'b100: return a & ~b;
            3'b101: return a | ~b;
            3'b110: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        chk({req, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mflags});
        chk("R9 v", {31'd0, flag_v}, 32'd0);
    endtask

    // Drive at negedge, check combinational outputs, then flags after the edge
    task automatic do_op(input string req, input logic v, input logic [2:0] op,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input logic sf);
        logic [W-1:0] r;
        logic probe;
        @(negedge clk);
        in_valid = v; opcode = op; src_a = a; src_b = b; shift_carry = c; set_flags = sf;
        #1;
        r = ref_res(op, a, b);
        probe = op[2] & op[1];
        chk({req, " R1 result"}, res_data, r);
        chk({req, " R3 we"}, {31'd0, res_we}, {31'd0, v & ~probe});
        if (v && (probe || sf)) mflags = {r[W-1], (r == '0), c, mflags[0]};
        @(posedge clk); #1;
        check_flags(req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; in_valid = 0; opcode = 0; src_a = 0; src_b = 0; shift_carry = 0; set_flags = 0;
        mflags = 4'b0000;
        repeat (3) @(posedge clk);
        #1;
        check_flags("R11 reset");
        @(negedge clk); rst = 0;

        // Directed corners
        do_op("R7 zero", 1, 3'b000, 32'hF0F0_0000, 32'h0F0F_FFFF, 1, 1);
        do_op("R6 neg",  1, 3'b001, 32'h8000_0000, 32'h0, 0, 1);
        do_op("R8 c1",   1, 3'b010, 32'h1234, 32'h1, 1, 1);
        do_op("R8 c0",   1, 3'b010, 32'h1234, 32'h1, 0, 1);
        do_op("R2 not a0", 1, 3'b011, 32'h0, 32'h00FF_00FF, 1, 1);
        do_op("R2 not a1", 1, 3'b011, 32'hFFFF_FFFF, 32'h00FF_00FF, 0, 0);
        do_op("R4 hold", 1, 3'b100, 32'h0, 32'h0, 1, 0);
        do_op("R5 probe and", 1, 3'b110, 32'hFFFF_0000, 32'h0000_FFFF, 1, 0);
        do_op("R5 probe xor", 1, 3'b111, 32'h8000_0001, 32'h0000_0001, 0, 0);
        do_op("R10 idle", 0, 3'b110, 32'h0, 32'h0, 1, 1);
        do_op("R10 idle wr", 0, 3'b001, 32'h8000_0000, 32'h0, 0, 1);
        do_op("R1 ornot", 1, 3'b101, 32'h0, 32'hFFFF_FFFF, 1, 1);

        // Every opcode with random operands
        for (int i = 0; i < 800; i++) begin
            logic [2:0] op;
            logic [W-1:0] a, b;
            op = 3'(i % 8);
            a = $urandom();
            b = $urandom();
            if (i % 13 == 0) b = a;
            do_op("R1 random", ($urandom() % 8) != 0, op, a, b, 1'($urandom()), 1'($urandom()));
        end

        // Reset after flags are set
        do_op("R11 pre", 1, 3'b011, 32'h0, 32'h0, 1, 1);
        @(negedge clk); rst = 1; in_valid = 0;
        @(posedge clk); #1;
        mflags = 4'b0000;
        check_flags("R11 mid reset");
        @(negedge clk); rst = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule